// File: doc/BRIEF.md
# CCD Electronic Shutter Sequencer

This block decides, line by line, when the substrate discharge pulse of a CCD sensor is applied. It also decides when the ternary readout pulses must be withheld. Each field it samples a shutter setting from the configuration bank: a two-bit mode, a field count, a line count and a target field index. It then works through a sequence of one or more fields. In each field it raises a per-line pulse enable on a run of consecutive lines that ends on the line just before the readout line.

A field count of zero gives a short exposure that fits inside one field. A non-zero field count stretches the exposure over that many extra fields. Until such a stretched sequence finishes, the block holds off any new configuration and raises a hold flag so that the loader upstream can see the lock. A separate mode leaves the pulse enable off and withholds readout, so the exposure already running carries on into the next field. The sync generator supplies the field and line strobes and the line index.

Top module: `ccd_shutter_seq`

## Requirements
- R1: After reset, and until the first field strobe, `sub_en`, `ro_stop` and `cfg_hold` are all low.
- R2: Shutter settings are taken only on a field strobe. A change to the settings during a field leaves the rest of that field as it was, and the change takes effect from the next field.
- R3: With mode 00 (stopped), `sub_en` stays low on every line, whatever the other settings are.
- R4: With mode 01 and a field count of 0, every field carries N = H+1 pulse lines, where H is the line count. These are the lines READ_LINE−N up to READ_LINE−1.
- R5: When `field_a` was high at the field strobe, the number of pulse lines is H−1. A line count of 0 or 1 then gives no pulse lines.
- R6: Bit 11 of the line count has no effect. Only bits 10:0 form H.
- R7: Line 0 and every line at or after READ_LINE never carry a pulse. The run is cut off at line 1 when N is at least READ_LINE.
- R8: With mode 01 and a field count V ≥ 1, a sequence lasts V+1 fields and pulses are issued only in field index 0 of it. In fields 0 to V−1, `cfg_hold` is high and new settings are ignored. They are taken at the strobe that follows field V.
- R9: Mode 10 behaves like mode 01, except that pulses are issued only in the field whose index within the sequence equals the placement value. If that value exceeds V, no pulses are issued.
- R10: With mode 11, `ro_stop` is high, `sub_en` stays low and `cfg_hold` stays low.
- R11: `sub_en` is registered. It changes only on the clock edge that takes a line strobe, and it is cleared on a field strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Shutter mode: 00 stopped, 01 normal, 10 placed, 11 readout stop |
| cfg_vcnt | input | VCNT_W | Number of extra fields in the exposure |
| cfg_hcnt | input | HCNT_W | Pulse line count; the top bit is ignored |
| cfg_place | input | VCNT_W | Field index that carries pulses in mode 10 |
| field_a | input | 1 | Current field is the A field of frame readout |
| field_start | input | 1 | Field start strobe, one cycle |
| line_start | input | 1 | Line start strobe, one cycle |
| line_idx | input | LINE_W | Line index within the field, valid with `line_start` |
| sub_en | output | 1 | Discharge pulse enable for the current line |
| ro_stop | output | 1 | Withhold ternary readout pulses this field |
| cfg_hold | output | 1 | Configuration update locked |

## Verification
The bench builds the block with READ_LINE = 12 and a five-bit line index, and runs fields of 16 lines. This makes the whole pulse window visible in every field. It also means a line count of 20 is enough to push the window against line 1, and bit 11 of the line count can be set to show that it has no effect. The field count and placement value keep their full ten-bit width. Small values of 1 and 2 are enough to step through every field of a stretched sequence, and a placement value of 5 lies beyond the sequence length.

// File: rtl/ccd_shutter_seq.sv
module ccd_shutter_seq #(
  parameter int VCNT_W    = 10,
  parameter int HCNT_W    = 12,
  parameter int LINE_W    = 11,
  parameter int READ_LINE = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic [VCNT_W-1:0] cfg_vcnt,
  input  logic [HCNT_W-1:0] cfg_hcnt,
  input  logic [VCNT_W-1:0] cfg_place,
  input  logic              field_a,
  input  logic              field_start,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_idx,
  output logic              sub_en,
  output logic              ro_stop,
  output logic              cfg_hold
);
  localparam int NW = HCNT_W - 1;
  localparam int SW = ((LINE_W > NW + 1) ? LINE_W : NW + 1) + 1;
  localparam logic [SW-1:0] RL = SW'(READ_LINE);

  logic [1:0]        mode_r;
  logic [VCNT_W-1:0] vcnt_r, place_r, fidx;
  logic [NW-1:0]     hcnt_r;
  logic              fa_r;
  logic              sub_q;

  logic shutter_on, seq_more, fire_field, in_win;
  logic [NW:0] n_pulse;

  assign shutter_on = (mode_r == 2'b01) || (mode_r == 2'b10);
  assign seq_more   = shutter_on && (fidx != vcnt_r);
  assign fire_field = shutter_on && (fidx == ((mode_r == 2'b10) ? place_r : '0));

  always_comb begin
    if (fa_r) n_pulse = (hcnt_r > NW'(1)) ? ({1'b0, hcnt_r} - 1'b1) : '0;
    else      n_pulse = {1'b0, hcnt_r} + 1'b1;
  end

  assign in_win = (line_idx != '0) && (SW'(line_idx) < RL) &&
                  ((SW'(line_idx) + SW'(n_pulse)) >= RL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r  <= 2'b00;
      vcnt_r  <= '0;
      hcnt_r  <= '0;
      place_r <= '0;
      fidx    <= '0;
      fa_r    <= 1'b0;
    end else if (field_start) begin
      fa_r <= field_a;
      if (seq_more) begin
        fidx <= fidx + 1'b1;
      end else begin
        fidx    <= '0;
        mode_r  <= cfg_mode;
        vcnt_r  <= cfg_vcnt;
        hcnt_r  <= cfg_hcnt[NW-1:0];
        place_r <= cfg_place;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sub_q <= 1'b0;
    else if (field_start) sub_q <= 1'b0;
    else if (line_start)  sub_q <= fire_field && in_win;
  end

  assign sub_en   = sub_q;
  assign ro_stop  = (mode_r == 2'b11);
  assign cfg_hold = seq_more;
endmodule

// File: rtl/ccd_shutter_seq_chk.sv
module ccd_shutter_seq_chk #(
  parameter int VCNT_W    = 10,
  parameter int HCNT_W    = 12,
  parameter int LINE_W    = 11,
  parameter int READ_LINE = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              field_start,
  input logic              line_start,
  input logic [LINE_W-1:0] line_idx,
  input logic              sub_en,
  input logic              ro_stop,
  input logic              cfg_hold,
  input logic [1:0]        mode_r,
  input logic [VCNT_W-1:0] vcnt_r,
  input logic [VCNT_W-1:0] fidx,
  input logic [HCNT_W-2:0] hcnt_r
);
  logic [LINE_W-1:0] last_line;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          last_line <= '0;
    else if (line_start) last_line <= line_idx;
  end

  AST_RO_NO_SUB: assert property (@(posedge clk) disable iff (!rst_n) ro_stop |-> !sub_en); // R10
  AST_RO_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ro_stop |-> !cfg_hold); // R10
  AST_STOP_NO_SUB: assert property (@(posedge clk) disable iff (!rst_n) (mode_r == 2'b00) |-> !sub_en); // R3
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (cfg_hold && field_start) |=> ($stable(vcnt_r) && $stable(hcnt_r) && $stable(mode_r))); // R8
  AST_FIDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) fidx <= vcnt_r); // R8
  AST_SUB_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) sub_en |-> ((last_line != '0) && (int'(last_line) < READ_LINE))); // R7
  AST_SUB_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (!line_start && !field_start) |=> $stable(sub_en)); // R11
endmodule

bind ccd_shutter_seq ccd_shutter_seq_chk #(
  .VCNT_W(VCNT_W), .HCNT_W(HCNT_W), .LINE_W(LINE_W), .READ_LINE(READ_LINE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_start(line_start),
  .line_idx(line_idx), .sub_en(sub_en), .ro_stop(ro_stop), .cfg_hold(cfg_hold),
  .mode_r(mode_r), .vcnt_r(vcnt_r), .fidx(fidx), .hcnt_r(hcnt_r)
);

// File: tb/test_ccd_shutter_seq.sv
module test_ccd_shutter_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RL = 12;
  localparam int NL = 16;

  logic        clk = 0, rst_n = 0;
  logic [1:0]  cfg_mode = 0;
  logic [9:0]  cfg_vcnt = 0, cfg_place = 0;
  logic [11:0] cfg_hcnt = 0;
  logic        field_a = 0, field_start = 0, line_start = 0;
  logic [4:0]  line_idx = 0;
  logic        sub_en, ro_stop, cfg_hold;
  int errors = 0, checks = 0;
  bit done = 0;

  ccd_shutter_seq #(.VCNT_W(10), .HCNT_W(12), .LINE_W(5), .READ_LINE(RL)) i_ccd_shutter_seq (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_vcnt(cfg_vcnt), .cfg_hcnt(cfg_hcnt),
    .cfg_place(cfg_place), .field_a(field_a), .field_start(field_start), .line_start(line_start),
    .line_idx(line_idx), .sub_en(sub_en), .ro_stop(ro_stop), .cfg_hold(cfg_hold));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_mask(input int n);
    logic [15:0] m = '0;
    for (int l = 1; l < RL; l++) if (l + n >= RL) m[l] = 1'b1;
    return m;
  endfunction

  task automatic run_field(input int chg_line, input logic [11:0] chg_h,
                           output logic [15:0] msk, output logic [15:0] pre,
                           output logic hold0, output logic ro0);
    msk = '0; pre = '0; hold0 = 0; ro0 = 0;
    for (int l = 0; l < NL; l++) begin
      @(negedge clk);
      pre[l] = sub_en;
      if (l == chg_line) cfg_hcnt = chg_h;
      line_start = 1; field_start = (l == 0); line_idx = 5'(l);
      @(negedge clk);
      line_start = 0; field_start = 0;
      msk[l] = sub_en;
      if (l == 0) begin hold0 = cfg_hold; ro0 = ro_stop; end
      @(negedge clk);
    end
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [9:0] v, input logic [11:0] h,
                         input logic [9:0] p);
    cfg_mode = m; cfg_vcnt = v; cfg_hcnt = h; cfg_place = p;
  endtask

  task automatic t_reset;
    check("R1 sub_en", sub_en, 0);
    check("R1 ro_stop", ro_stop, 0);
    check("R1 cfg_hold", cfg_hold, 0);
  endtask

  task automatic t_stopped;
    logic [15:0] m, p; logic h, r;
    set_cfg(2'b00, 10'd0, 12'd5, 10'd0);
    run_field(-1, 0, m, p, h, r);
    check("R3 stopped mask", m, 0);
    check("R3 stopped ro_stop", r, 0);
  endtask

  task automatic t_high_speed;
    logic [15:0] m, p; logic h, r;
    set_cfg(2'b01, 10'd0, 12'd3, 10'd0);
    run_field(-1, 0, m, p, h, r);
    check("R4 first field mask", m, exp_mask(4));
    check("R4 no hold", h, 0);
    run_field(-1, 0, m, p, h, r);
    check("R4 repeat field mask", m, exp_mask(4));
    check("R11 sub_en before strobe", p, {exp_mask(4)[14:0], 1'b0});
  endtask

  task automatic t_msb_ignored;
    logic [15:0] m, p; logic h, r;
    set_cfg(2'b01, 10'd0, 12'h803, 10'd0);
    run_field(-1, 0, m, p, h, r);
    check("R6 top bit ignored", m, exp_mask(4));
  endtask

  task automatic t_field_a;
    logic [15:0] m, p; logic h, r;
    field_a = 1;
    set_cfg(2'b01, 10'd0, 12'd3, 10'd0);
    run_field(-1, 0, m, p, h, r);
    check("R5 A field count-1", m, exp_mask(2));
    set_cfg(2'b01, 10'd0, 12'd1, 10'd0);
    run_field(-1, 0, m, p, h, r);
    check("R5 A field none", m, 0);
    field_a = 0;
  endtask

  task automatic t_clamp;
    logic [15:0] m, p; logic h, r;
    set_cfg(2'b01, 10'd0, 12'd20, 10'd0);
    run_field(-1, 0, m, p, h, r);
    check("R7 clamp at line 1", m, 16'h0FFE);
  endtask

  task automatic t_mid_change;
    logic [15:0] m, p; logic h, r;
    set_cfg(2'b01, 10'd0, 12'd3, 10'd0);
    run_field(5, 12'd0, m, p, h, r);
    check("R2 change held this field", m, exp_mask(4));
    run_field(-1, 0, m, p, h, r);
    check("R2 change next field", m, exp_mask(1));
  endtask

  task automatic t_low_speed;
    logic [15:0] m, p; logic h, r;
    set_cfg(2'b01, 10'd2, 12'd3, 10'd0);
    run_field(-1, 0, m, p, h, r);
    check("R8 field0 mask", m, exp_mask(4));
    check("R8 field0 hold", h, 1);
    set_cfg(2'b01, 10'd0, 12'd1, 10'd0);
    run_field(-1, 0, m, p, h, r);
    check("R8 field1 mask", m, 0);
    check("R8 field1 hold", h, 1);
    run_field(-1, 0, m, p, h, r);
    check("R8 field2 mask", m, 0);
    check("R8 field2 hold", h, 0);
    run_field(-1, 0, m, p, h, r);
    check("R8 new cfg taken", m, exp_mask(2));
  endtask

  task automatic t_placed;
    logic [15:0] m, p; logic h, r;
    set_cfg(2'b10, 10'd2, 12'd3, 10'd1);
    run_field(-1, 0, m, p, h, r);
    check("R9 placed field0", m, 0);
    check("R9 placed hold", h, 1);
    run_field(-1, 0, m, p, h, r);
    check("R9 placed field1", m, exp_mask(4));
    run_field(-1, 0, m, p, h, r);
    check("R9 placed field2", m, 0);
    set_cfg(2'b10, 10'd1, 12'd3, 10'd5);
    run_field(-1, 0, m, p, h, r);
    check("R9 out of range f0", m, 0);
    run_field(-1, 0, m, p, h, r);
    check("R9 out of range f1", m, 0);
  endtask

  task automatic t_ro_stop;
    logic [15:0] m, p; logic h, r;
    set_cfg(2'b11, 10'd3, 12'd3, 10'd0);
    run_field(-1, 0, m, p, h, r);
    check("R10 ro_stop", r, 1);
    check("R10 no sub", m, 0);
    check("R10 no hold", h, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_stopped();
    t_high_speed();
    t_msb_ignored();
    t_field_a();
    t_clamp();
    t_mid_change();
    t_low_speed();
    t_placed();
    t_ro_stop();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule